// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block sits inside a 16550-compatible UART and turns five raw interrupt condition flags into a single interrupt line and an identification byte for the CPU. The five conditions are line status, data available, character timeout, transmit holding register empty and modem status. Software writes an enable byte that masks each source. It reads the identification byte to learn the most urgent enabled source and jumps to the matching service routine.

The identification byte is registered, so it follows the live conditions with one clock of latency. While the CPU read strobe is high, the byte stays frozen, so a read never sees a half-updated value. Conditions that change during the read still reach the interrupt line. They appear in the byte on the first clock edge after the strobe drops. The transmit-empty source is the only one this block owns:

- It is latched on a rising edge of the transmitter's empty flag.
- It is dropped when a read starts while it is the reported source.
- It is also dropped when the empty flag falls.

Top module: `uart_irq_ident`

## Requirements
- R1: The enable register `ier_o` is 0x00 after reset. A write stores bits 3:0 of `ier_wdata_i`, and bits 7:4 always read 0. Bit 0 enables data available and timeout, bit 1 enables transmit empty, bit 2 enables line status, and bit 3 enables modem status.
- R2: Bit 0 of `iir_o` is 0 when any enabled source is pending and 1 when none is. With none pending, bits 3:0 read 0001.
- R3: Bits 3:0 of `iir_o` report the highest enabled pending source. The order from highest to lowest is: line status 0110, data available 0100, timeout 1100, transmit empty 0010, modem status 0000.
- R4: A timeout is recognised only when `fifo_en_i` is 1, and bit 3 of `iir_o` is 0 in every other case. When data available and timeout are both pending, data available is reported.
- R5: Bits 7:6 of `iir_o` read 11 when FIFO mode was in effect at capture time and 00 otherwise. Bits 5:4 always read 0.
- R6: A disabled source never appears in `iir_o` and never asserts `intr_o`. With all four enable bits clear, `intr_o` stays 0.
- R7: `iir_o` captures the live value on every clock edge at which `iir_rd_i` is 0. It holds its value on every edge at which `iir_rd_i` is 1, and events that arrive during the hold show up on the first edge after the strobe drops.
- R8: The transmit-empty pending flag is set on the clock edge that sees `thre_i` go from 0 to 1. It is cleared while `thre_i` is 0. It is also cleared on the edge where `iir_rd_i` rises while `iir_o[3:0]` is 0010, and it stays clear while `thre_i` remains 1.
- R9: `intr_o` is the registered OR of all enabled pending sources, one clock after the inputs. It keeps updating while `iir_rd_i` is 1.
- R10: During and after reset, `iir_o` is 0x01 and `intr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO mode in effect |
| ier_we_i | input | 1 | Write strobe for the enable register |
| ier_wdata_i | input | 8 | Enable register write data |
| ier_o | output | 8 | Enable register readback |
| iir_rd_i | input | 1 | Identification register read access, high for its duration |
| lsr_int_i | input | 1 | Line status condition |
| rda_int_i | input | 1 | Received data available condition |
| cto_int_i | input | 1 | Character timeout condition |
| thre_i | input | 1 | Transmit holding register empty flag |
| msr_int_i | input | 1 | Modem status condition |
| iir_o | output | 8 | Identification byte |
| intr_o | output | 1 | Interrupt request |

## Verification
Two situations are hardest to reach from the ports.

The first is a new condition arriving while a read holds the identification byte. The stimulus raises the read strobe, then raises line status under the hold. It then checks three things: the byte stays frozen, the interrupt line rises anyway, and the byte changes on the first edge after release.

The second is a transmit-empty clear by read while the empty flag stays high. Random rounds fire one-cycle read strobes after the byte has settled, with `thre_i` often held at 1 across rounds. A cleared source must then stay absent until the flag falls and rises again.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int REG_W = 8;
  localparam int EN_W  = 4;

  localparam int EN_RDA  = 0;
  localparam int EN_THRE = 1;
  localparam int EN_LSR  = 2;
  localparam int EN_MSR  = 3;

  typedef enum logic [3:0] {
    NIB_LSR  = 4'b0110,
    NIB_RDA  = 4'b0100,
    NIB_CTO  = 4'b1100,
    NIB_THRE = 4'b0010,
    NIB_MSR  = 4'b0000,
    NIB_NONE = 4'b0001
  } iir_nib_e;
endpackage

// File: rtl/uart_irq_ier.sv
module uart_irq_ier
  import uart_irq_pkg::*;
#(
  parameter int REG_W_P = REG_W,
  parameter int EN_W_P  = EN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [REG_W_P-1:0] wdata_i,
  output logic [REG_W_P-1:0] ier_o
);
  localparam logic [REG_W_P-1:0] WR_MASK = REG_W_P'((1 << EN_W_P) - 1);

  logic [REG_W_P-1:0] ier_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ier_q <= '0;
    else if (we_i) ier_q <= wdata_i & WR_MASK;
  end

  assign ier_o = ier_q;

  AST_IER_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ier_o[REG_W_P-1:EN_W_P] == '0); // R1
endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic thre_i,
  input  logic rd_start_i,
  input  logic reported_i,
  output logic pend_o
);
  logic thre_q, pend_q, set_w, clr_w;

  assign set_w = thre_i & ~thre_q;
  assign clr_w = ~thre_i | (rd_start_i & reported_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thre_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      thre_q <= thre_i;
      if (set_w)      pend_q <= 1'b1;
      else if (clr_w) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  AST_THRE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thre_i && !thre_q) |=> pend_o); // R8
  AST_THRE_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_start_i && reported_i && thre_q) |=> !pend_o); // R8
  AST_THRE_LOW_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !thre_i |=> !pend_o); // R8
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int REG_W_P = REG_W,
  parameter int EN_W_P  = EN_W
) (
  input  logic [EN_W_P-1:0]  en_i,
  input  logic               fifo_en_i,
  input  logic               lsr_i,
  input  logic               rda_i,
  input  logic               cto_i,
  input  logic               thre_i,
  input  logic               msr_i,
  output logic [REG_W_P-1:0] iir_o,
  output logic               any_o
);
  logic lsr_e, rda_e, cto_e, thre_e, msr_e;
  iir_nib_e nib;

  assign lsr_e  = lsr_i  & en_i[EN_LSR];
  assign rda_e  = rda_i  & en_i[EN_RDA];
  assign cto_e  = cto_i  & en_i[EN_RDA] & fifo_en_i;
  assign thre_e = thre_i & en_i[EN_THRE];
  assign msr_e  = msr_i  & en_i[EN_MSR];

  assign any_o = lsr_e | rda_e | cto_e | thre_e | msr_e;

  always_comb begin
    if (lsr_e)       nib = NIB_LSR;
    else if (rda_e)  nib = NIB_RDA;
    else if (cto_e)  nib = NIB_CTO;
    else if (thre_e) nib = NIB_THRE;
    else if (msr_e)  nib = NIB_MSR;
    else             nib = NIB_NONE;
  end

  always_comb begin
    iir_o = '0;
    iir_o[3:0] = nib;
    iir_o[REG_W_P-1:REG_W_P-2] = {2{fifo_en_i}};
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int REG_W_P = REG_W,
  parameter int EN_W_P  = EN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fifo_en_i,
  input  logic               ier_we_i,
  input  logic [REG_W_P-1:0] ier_wdata_i,
  output logic [REG_W_P-1:0] ier_o,
  input  logic               iir_rd_i,
  input  logic               lsr_int_i,
  input  logic               rda_int_i,
  input  logic               cto_int_i,
  input  logic               thre_i,
  input  logic               msr_int_i,
  output logic [REG_W_P-1:0] iir_o,
  output logic               intr_o
);
  localparam logic [REG_W_P-1:0] IIR_RST = REG_W_P'(NIB_NONE);

  logic [REG_W_P-1:0] ier_w, iir_live, iir_q;
  logic any_w, intr_q, rd_q, rd_start, thre_pend, thre_rep;

  uart_irq_ier #(.REG_W_P(REG_W_P), .EN_W_P(EN_W_P)) u_ier (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ier_we_i),
    .wdata_i (ier_wdata_i),
    .ier_o   (ier_w)
  );

  assign rd_start = iir_rd_i & ~rd_q;
  assign thre_rep = (iir_q[3:0] == NIB_THRE);

  uart_irq_thre u_thre (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .thre_i     (thre_i),
    .rd_start_i (rd_start),
    .reported_i (thre_rep),
    .pend_o     (thre_pend)
  );

  uart_irq_prio #(.REG_W_P(REG_W_P), .EN_W_P(EN_W_P)) u_prio (
    .en_i      (ier_w[EN_W_P-1:0]),
    .fifo_en_i (fifo_en_i),
    .lsr_i     (lsr_int_i),
    .rda_i     (rda_int_i),
    .cto_i     (cto_int_i),
    .thre_i    (thre_pend),
    .msr_i     (msr_int_i),
    .iir_o     (iir_live),
    .any_o     (any_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= 1'b0;
      iir_q  <= IIR_RST;
      intr_q <= 1'b0;
    end else begin
      rd_q   <= iir_rd_i;
      intr_q <= any_w;
      if (!iir_rd_i) iir_q <= iir_live; // frozen during CPU access
    end
  end

  assign ier_o  = ier_w;
  assign iir_o  = iir_q;
  assign intr_o = intr_q;

  AST_IIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_rd_i |=> $stable(iir_o)); // R7
  AST_NONE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[0] |-> iir_o[3:1] == 3'b000); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[5:4] == 2'b00); // R5
  AST_B3_FIFO_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iir_o[REG_W_P-1:REG_W_P-2] == 2'b00 |-> !iir_o[3]); // R4
  AST_INTR_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ier_o[EN_W_P-1:0] == '0 |=> !intr_o); // R6
endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic fifo_en, ier_we, iir_rd, lsr, rda, cto, thre, msr;
  logic [7:0] ier_wdata, ier_o, iir_o;
  logic intr_o;

  int checks = 0, errors = 0;
  logic [3:0] ier_m = 4'h0;
  logic thre_pend_m = 1'b0, thre_prev_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_irq_ident u_uart_irq_ident (
    .clk_i(clk), .rst_ni(rst_ni), .fifo_en_i(fifo_en), .ier_we_i(ier_we),
    .ier_wdata_i(ier_wdata), .ier_o(ier_o), .iir_rd_i(iir_rd),
    .lsr_int_i(lsr), .rda_int_i(rda), .cto_int_i(cto), .thre_i(thre),
    .msr_int_i(msr), .iir_o(iir_o), .intr_o(intr_o)
  );

  function automatic logic [3:0] exp_nib();
    if (lsr && ier_m[2])                  return 4'b0110;
    if (rda && ier_m[0])                  return 4'b0100;
    if (cto && ier_m[0] && fifo_en)       return 4'b1100;
    if (thre_pend_m && ier_m[1])          return 4'b0010;
    if (msr && ier_m[3])                  return 4'b0000;
    return 4'b0001;
  endfunction

  function automatic logic [7:0] exp_iir();
    return {{2{fifo_en}}, 2'b00, exp_nib()};
  endfunction

  function automatic logic exp_intr();
    return exp_nib() != 4'b0001;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_raw(logic l, logic r, logic c, logic t, logic m, logic f);
    lsr = l; rda = r; cto = c; msr = m; fifo_en = f; thre = t;
    if (t && !thre_prev_m) thre_pend_m = 1'b1;
    if (!t) thre_pend_m = 1'b0;
    thre_prev_m = t;
  endtask

  task automatic wr_ier(logic [7:0] d);
    ier_we = 1'b1; ier_wdata = d; ier_m = d[3:0];
    step(1);
    ier_we = 1'b0;
  endtask

  task automatic rd_pulse();
    if (exp_nib() == 4'b0010) thre_pend_m = 1'b0; // R8
    iir_rd = 1'b1;
    step(1);
    iir_rd = 1'b0;
  endtask

  task automatic chk_all(string req);
    chk(req, iir_o, exp_iir());
    chk(req, {7'd0, intr_o}, {7'd0, exp_intr()});
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    fifo_en = 0; ier_we = 0; ier_wdata = 0; iir_rd = 0;
    lsr = 0; rda = 0; cto = 0; thre = 0; msr = 0;
    step(2);
    chk("R10 iir reset", iir_o, 8'h01);
    chk("R10 intr reset", {7'd0, intr_o}, 8'h00);
    chk("R1 ier reset", ier_o, 8'h00);
    rst_ni = 1'b1;
    step(2);

    wr_ier(8'hFF); step(1);
    chk("R1 ier high bits", ier_o, 8'h0F);

    set_raw(0, 0, 1, 0, 0, 0); wr_ier(8'h01); step(1);
    chk("R4 timeout ignored non-fifo", iir_o, 8'h01);
    set_raw(0, 0, 1, 0, 0, 1); step(2);
    chk("R4 timeout fifo", iir_o, 8'hCC);
    set_raw(0, 1, 1, 0, 0, 1); step(2);
    chk("R4 rda over timeout", iir_o, 8'hC4);

    set_raw(1, 1, 1, 1, 1, 1); wr_ier(8'h00); step(1);
    chk("R6 all masked iir", iir_o, 8'hC1);
    chk("R6 all masked intr", {7'd0, intr_o}, 8'h00);

    wr_ier(8'h0F); step(1);
    chk("R3 lsr top", iir_o, 8'hC6);
    set_raw(0, 0, 0, 1, 1, 0); step(2);
    chk("R3 thre over msr", iir_o, 8'h02);
    chk("R5 fifo bits off", {6'd0, iir_o[7:6]}, 8'h00);
    rd_pulse(); step(1);
    chk("R8 thre cleared by read", iir_o, 8'h00);
    step(3);
    chk("R8 thre stays clear while high", iir_o, 8'h00);

    set_raw(0, 0, 0, 0, 0, 0); step(2);
    chk_all("R2 none pending");
    iir_rd = 1'b1; step(1);
    set_raw(1, 0, 0, 0, 0, 0); step(2);
    chk("R7 held during read", iir_o, 8'h01);
    chk("R9 intr during read", {7'd0, intr_o}, 8'h01);
    iir_rd = 1'b0; step(1);
    chk("R7 update after release", iir_o, 8'h06);

    void'($urandom(32'h5EED));
    for (int i = 0; i < 400; i++) begin
      logic [7:0] r = 8'($urandom);
      if (r[7]) wr_ier(8'($urandom));
      set_raw(r[0], r[1], r[2], (r[3] | r[6]), r[4], r[5]);
      step(2);
      chk_all("R3 R4 R5 R6 random");
      chk("R1 random ier", ier_o, {4'd0, ier_m});
      if (($urandom % 3) == 0) begin
        rd_pulse();
        step(1);
        chk_all("R8 random read");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule